// File: doc/BRIEF.md
# Memory Mode Register Load Controller

This block holds the main mode word of a DDR2-style memory device model. A load command is accepted only when the bank-address pair is zero and every bank is precharged. It then writes the whole word at once, taken from the address bus. It also tracks which banks are open from activate and precharge commands, so it can decide whether a load is allowed.

After an accepted load, a lockout window of programmable length starts. Any command other than a no-operation that arrives inside the window is dropped and reported as an error. The DLL-reset bit of the word clears itself one cycle after it is written, and that cycle doubles as a single DLL-reset pulse. Decoded fields are presented next to the raw word: burst length, burst type, CAS latency and write recovery. A parameter selects a 14-bit word or a 13-bit word for the wide organisation.

Top module: `mode_load_ctrl`

## Requirements
- R1: While reset is applied, and after it is released until the first command, mode_o is 0, busy_o, err_o and dll_rst_o are 0, bl_o is 0 and bl_bad_o is 1.
- R2: A load (cmd_i = 1) with ba_i = 00, all banks precharged and busy_o low stores the whole of addr_i. mode_o equals it in the following cycle.
- R3: A load with ba_i other than 00 leaves mode_o unchanged, raises no error and starts no lockout.
- R4: A load with ba_i = 00 while any bank is open sets err_o for the following cycle. It leaves mode_o unchanged and starts no lockout.
- R5: After an accepted load at edge k with tMRD = t, busy_o is high while fewer than t-1 edges have passed. A non-NOP command at edge k+j with j < t is dropped and sets err_o for the next cycle. A command at edge k+t is executed normally.
- R6: Bit 8 of mode_o (DLL reset) reads as written only in the cycle after the load and reads 0 from then on. dll_rst_o equals that bit, which makes it a single-cycle pulse.
- R7: Bits 2..0 of the word set the burst length: 010 gives bl_o = 4 and 011 gives bl_o = 8, both with bl_bad_o = 0. Any other code gives bl_o = 0 and bl_bad_o = 1.
- R8: bt_o is bit 3, cl_o is bits 6..4, and wr_o equals bits 11..9 plus one.
- R9: An activate (cmd_i = 2) opens bank_i. A precharge (cmd_i = 3) closes only bank_i. A precharge-all (cmd_i = 4) closes every bank. Command 0 is a no-operation, and codes 5 to 7 are other commands that change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tmrd_i | input | TW | Lockout length in cycles after a load |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_i | input | 3 | Command code |
| ba_i | input | 2 | Bank-address pair of a load |
| bank_i | input | BW | Bank index for activate and precharge |
| addr_i | input | MW | Mode word carried by a load |
| mode_o | output | MW | Stored mode word |
| bl_o | output | 4 | Decoded burst length, 0 if invalid |
| bl_bad_o | output | 1 | Burst-length code invalid |
| bt_o | output | 1 | Burst type bit |
| cl_o | output | 3 | CAS latency field |
| wr_o | output | 4 | Write recovery in cycles |
| dll_rst_o | output | 1 | DLL-reset pulse |
| busy_o | output | 1 | Lockout window active |
| err_o | output | 1 | Illegal command seen in the previous cycle |

## Verification
The hardest condition to reach is the last edge of the lockout window, where a dropped command and an accepted one are a single cycle apart. The stimulus sweeps tMRD from 1 to 6. For each value it places an activate at every offset after a load and reads back both busy_o and err_o. A rejected load needs an open bank, so the bench first opens banks with activates. It then closes them one at a time or all together, and probes the bank state through whether the next load succeeds. An exhaustive pass over all 16384 mode words covers the decode and the self-clearing bit.

// File: rtl/mlc_pkg.sv
package mlc_pkg;
  localparam logic [2:0] CMD_NOP  = 3'd0;
  localparam logic [2:0] CMD_LOAD = 3'd1;
  localparam logic [2:0] CMD_ACT  = 3'd2;
  localparam logic [2:0] CMD_PRE  = 3'd3;
  localparam logic [2:0] CMD_PREA = 3'd4;

  localparam int unsigned DLL_BIT = 8;

  function automatic logic [3:0] bl_decode(input logic [2:0] code);
    case (code)
      3'b010:  bl_decode = 4'd4;
      3'b011:  bl_decode = 4'd8;
      default: bl_decode = 4'd0;
    endcase
  endfunction
endpackage

// File: rtl/mlc_bank_track.sv
module mlc_bank_track #(
  parameter int unsigned NB = 4,
  localparam int unsigned BW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          act_i,
  input  logic          pre_i,
  input  logic          prea_i,
  input  logic [BW-1:0] bank_i,
  output logic          all_pre_o
);
  logic [NB-1:0] open_q;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) open_q[b] <= 1'b0;
      else if (prea_i) open_q[b] <= 1'b0;
      else if (bank_i == BW'(b)) begin
        if (act_i) open_q[b] <= 1'b1;
        else if (pre_i) open_q[b] <= 1'b0;
      end
    end
  end

  assign all_pre_o = ~|open_q;
endmodule

// File: rtl/mlc_lockout.sv
module mlc_lockout #(
  parameter int unsigned TW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [TW-1:0] tmrd_i,
  output logic          busy_o
);
  logic [TW-1:0] cnt_q;

  // window covers edges k+1 .. k+tmrd-1
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (start_i) cnt_q <= (tmrd_i == '0) ? '0 : tmrd_i - TW'(1);
    else if (cnt_q != '0) cnt_q <= cnt_q - TW'(1);
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/mlc_mode_reg.sv
module mlc_mode_reg #(
  parameter int unsigned MW = 14
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [MW-1:0] data_i,
  output logic [MW-1:0] mode_o
);
  import mlc_pkg::*;
  logic [MW-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else if (wr_i) q <= data_i;
    else q[DLL_BIT] <= 1'b0;  // self-clearing bit
  end

  assign mode_o = q;
endmodule

// File: rtl/mlc_field_dec.sv
module mlc_field_dec #(
  parameter int unsigned MW = 14
) (
  input  logic [MW-1:0] mode_i,
  output logic [3:0]    bl_o,
  output logic          bl_bad_o,
  output logic          bt_o,
  output logic [2:0]    cl_o,
  output logic [3:0]    wr_o,
  output logic          dll_rst_o
);
  import mlc_pkg::*;

  always_comb begin
    bl_o      = bl_decode(mode_i[2:0]);
    bl_bad_o  = (bl_o == 4'd0);
    bt_o      = mode_i[3];
    cl_o      = mode_i[6:4];
    wr_o      = {1'b0, mode_i[11:9]} + 4'd1;
    dll_rst_o = mode_i[DLL_BIT];
  end
endmodule

// File: rtl/mode_load_ctrl.sv
module mode_load_ctrl #(
  parameter bit          X16 = 1'b0,
  parameter int unsigned NB  = 4,
  parameter int unsigned TW  = 4,
  localparam int unsigned MW = X16 ? 13 : 14,
  localparam int unsigned BW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [TW-1:0] tmrd_i,
  input  logic          cmd_valid_i,
  input  logic [2:0]    cmd_i,
  input  logic [1:0]    ba_i,
  input  logic [BW-1:0] bank_i,
  input  logic [MW-1:0] addr_i,
  output logic [MW-1:0] mode_o,
  output logic [3:0]    bl_o,
  output logic          bl_bad_o,
  output logic          bt_o,
  output logic [2:0]    cl_o,
  output logic [3:0]    wr_o,
  output logic          dll_rst_o,
  output logic          busy_o,
  output logic          err_o
);
  import mlc_pkg::*;

  logic cmd_act, cmd_go, is_mr_load, all_pre, load_ok, err_d, err_q;

  assign cmd_act    = cmd_valid_i && (cmd_i != CMD_NOP);
  assign cmd_go     = cmd_act && !busy_o;
  assign is_mr_load = (cmd_i == CMD_LOAD) && (ba_i == 2'b00);
  assign load_ok    = cmd_go && is_mr_load && all_pre;
  assign err_d      = (cmd_act && busy_o) || (cmd_go && is_mr_load && !all_pre);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else err_q <= err_d;
  end
  assign err_o = err_q;

  mlc_bank_track #(.NB(NB)) u_banks (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .act_i     (cmd_go && (cmd_i == CMD_ACT)),
    .pre_i     (cmd_go && (cmd_i == CMD_PRE)),
    .prea_i    (cmd_go && (cmd_i == CMD_PREA)),
    .bank_i    (bank_i),
    .all_pre_o (all_pre)
  );

  mlc_lockout #(.TW(TW)) u_lock (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (load_ok),
    .tmrd_i  (tmrd_i),
    .busy_o  (busy_o)
  );

  mlc_mode_reg #(.MW(MW)) u_mreg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (load_ok),
    .data_i (addr_i),
    .mode_o (mode_o)
  );

  mlc_field_dec #(.MW(MW)) u_dec (
    .mode_i    (mode_o),
    .bl_o      (bl_o),
    .bl_bad_o  (bl_bad_o),
    .bt_o      (bt_o),
    .cl_o      (cl_o),
    .wr_o      (wr_o),
    .dll_rst_o (dll_rst_o)
  );
endmodule

// File: rtl/mode_load_ctrl_chk.sv
module mode_load_ctrl_chk #(
  parameter int unsigned MW = 14
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cmd_valid_i,
  input logic [2:0]    cmd_i,
  input logic [1:0]    ba_i,
  input logic [MW-1:0] mode_o,
  input logic [3:0]    bl_o,
  input logic          bl_bad_o,
  input logic          dll_rst_o,
  input logic          busy_o,
  input logic          err_o
);
  localparam logic [MW-1:0] KEEP = ~(MW'(1) << 8);

  assert_lock_reject_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_i != 3'd0 && busy_o) |=> err_o);

  assert_other_ba_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_i == 3'd1 && ba_i != 2'b00 && !busy_o)
      |=> (!err_o && !busy_o && ((mode_o & KEEP) == ($past(mode_o) & KEEP))));

  assert_dll_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o[8] |=> !mode_o[8]);

  assert_dll_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dll_rst_o |=> !dll_rst_o);

  assert_bl8_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bl_o == 4'd8) |-> (mode_o[2:0] == 3'b011 && !bl_bad_o));

  assert_bl_bad_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bl_bad_o |-> (bl_o == 4'd0 && mode_o[2:1] != 2'b01));
endmodule

bind mode_load_ctrl mode_load_ctrl_chk #(.MW(MW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_i       (cmd_i),
  .ba_i        (ba_i),
  .mode_o      (mode_o),
  .bl_o        (bl_o),
  .bl_bad_o    (bl_bad_o),
  .dll_rst_o   (dll_rst_o),
  .busy_o      (busy_o),
  .err_o       (err_o)
);

// File: tb/tb_mode_load_ctrl.sv
module tb_mode_load_ctrl;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  tmrd = 4'd1;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd = 3'd0;
  logic [1:0]  ba = 2'd0;
  logic [1:0]  bank = 2'd0;
  logic [13:0] addr = '0;
  logic [13:0] mode;
  logic [3:0]  bl, wr;
  logic [2:0]  cl;
  logic        bl_bad, bt, dll, busy, err;
  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  mode_load_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .tmrd_i(tmrd), .cmd_valid_i(cmd_valid),
    .cmd_i(cmd), .ba_i(ba), .bank_i(bank), .addr_i(addr), .mode_o(mode),
    .bl_o(bl), .bl_bad_o(bl_bad), .bt_o(bt), .cl_o(cl), .wr_o(wr),
    .dll_rst_o(dll), .busy_o(busy), .err_o(err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] c, input logic [1:0] b, input logic [1:0] bk,
                       input logic [13:0] a);
    @(negedge clk);
    cmd_valid = 1'b1; cmd = c; ba = b; bank = bk; addr = a;
    @(posedge clk);
    #2;
  endtask

  task automatic idle(input int cycles);
    for (int i = 0; i < cycles; i++) drive(3'd0, 2'd0, 2'd0, '0);
  endtask

  function automatic logic [3:0] exp_bl(input logic [2:0] c);
    return (c == 3'b010) ? 4'd4 : (c == 3'b011) ? 4'd8 : 4'd0;
  endfunction

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk("R1 mode in reset", mode, 0);
    chk("R1 err in reset", err, 0);
    @(negedge clk); rst_ni = 1'b1;
    @(posedge clk); #2;
    chk("R1 mode", mode, 0);
    chk("R1 busy", busy, 0);
    chk("R1 dll", dll, 0);
    chk("R1 bl", bl, 0);
    chk("R1 bl_bad", bl_bad, 1);

    // exhaustive word sweep, no lockout
    tmrd = 4'd1;
    for (int w = 0; w < 16384; w++) begin
      logic [13:0] v = 14'(w);
      drive(3'd1, 2'd0, 2'd0, v);
      chk("R2 word", mode, v);
      chk("R6 dll pulse", dll, v[8]);
      chk("R7 bl", bl, exp_bl(v[2:0]));
      chk("R7 bl_bad", bl_bad, exp_bl(v[2:0]) == 4'd0);
      chk("R8 bt", bt, v[3]);
      chk("R8 cl", cl, v[6:4]);
      chk("R8 wr", wr, 32'(v[11:9]) + 1);
      chk("R2 err", err, 0);
      drive(3'd0, 2'd0, 2'd0, '0);
      chk("R6 self clear", mode, v & 14'h3EFF);
      chk("R6 dll low", dll, 0);
    end

    // R3 other bank-address pairs
    drive(3'd1, 2'd0, 2'd0, 14'h0A42);
    for (int b = 1; b < 4; b++) begin
      drive(3'd1, 2'(b), 2'd0, 14'h15BD);
      chk("R3 mode kept", mode, 14'h0A42);
      chk("R3 no err", err, 0);
      chk("R3 no lockout", busy, 0);
    end

    // R5 lockout boundary sweep
    for (int t = 1; t <= 6; t++) begin
      for (int j = 1; j <= t; j++) begin
        tmrd = 4'(t);
        drive(3'd1, 2'd0, 2'd0, 14'h0632);
        chk("R5 busy after load", busy, t > 1);
        for (int i = 1; i < j; i++) begin
          drive(3'd0, 2'd0, 2'd0, '0);
          chk("R5 busy window", busy, i < t - 1);
        end
        drive(3'd2, 2'd0, 2'd1, '0);
        chk("R5 act at offset", err, j < t);
        idle(8);
        drive(3'd4, 2'd0, 2'd0, '0);
        chk("R5 prea ok", err, 0);
      end
    end

    // R5 load inside lockout is dropped
    tmrd = 4'd4;
    drive(3'd1, 2'd0, 2'd0, 14'h0042);
    drive(3'd1, 2'd0, 2'd0, 14'h0073);
    chk("R5 load rejected err", err, 1);
    chk("R5 load rejected mode", mode, 14'h0042);
    idle(4);

    // R4 and R9 bank state
    drive(3'd2, 2'd0, 2'd2, '0);
    drive(3'd1, 2'd0, 2'd0, 14'h0163);
    chk("R4 open bank err", err, 1);
    chk("R4 mode kept", mode, 14'h0042);
    chk("R4 no lockout", busy, 0);
    drive(3'd3, 2'd0, 2'd2, '0);
    drive(3'd1, 2'd0, 2'd0, 14'h0163);
    chk("R9 pre closes bank", err, 0);
    chk("R9 load after pre", mode, 14'h0163);
    idle(4);
    drive(3'd2, 2'd0, 2'd1, '0);
    drive(3'd3, 2'd0, 2'd0, '0);
    drive(3'd1, 2'd0, 2'd0, 14'h0012);
    chk("R9 pre other bank keeps open", err, 1);
    drive(3'd5, 2'd0, 2'd1, '0);
    drive(3'd1, 2'd0, 2'd0, 14'h0012);
    chk("R9 other cmd no state", err, 1);
    drive(3'd2, 2'd0, 2'd0, '0);
    drive(3'd2, 2'd0, 2'd3, '0);
    drive(3'd4, 2'd0, 2'd0, '0);
    drive(3'd1, 2'd0, 2'd0, 14'h0012);
    chk("R9 prea closes all", err, 0);
    chk("R9 load after prea", mode, 14'h0012);

    finish_run();
  end
endmodule